// File: doc/BRIEF.md
# Two-Threshold Cross-Neighbourhood Zero Suppressor

This block thins out a two-dimensional array of unsigned samples, for example readout channels against time bins, that arrives one row at a time in raster order. It keeps a sample only if the sample lies inside a cluster of significant values and drops every other sample. To decide this it looks at five values: the sample itself and its four direct neighbours, the one above, the one below, the one to the left and the one to the right. The keep test uses two programmable thresholds. A high threshold picks out clusters. A lower threshold pulls in the quieter samples at the edge of a selected cluster.

Samples enter with their row and column index. The block stores the two most recent rows in line buffers. A sample can only be judged once the sample directly below it has arrived, so the verdict comes out one row later. Each sample that passes leaves on a registered output stream, carrying its original value and its row and column.

The last row has no row below it. When the final sample of a frame is accepted, the block therefore runs an internal sweep of COLS cycles with the lower neighbour forced to zero. The source must send nothing during those cycles and must start each frame at row 0.

Top module: `zs_cross2d`

## Requirements
- R1: A sample is kept if, and only if, at least one of its five cross values is strictly greater than `thr_hi` and at least two of the five are strictly greater than `thr_lo`. All comparisons are unsigned; a value equal to a threshold does not count.
- R2: A neighbour position outside the array reads as zero. This covers the row above row 0, the row below row ROWS-1, the column left of column 0 and the column right of column COLS-1.
- R3: A kept sample leaves with `out_data` equal to the sample value as it was received, `out_row` equal to its row and `out_col` equal to its column. Row and column are zero-based.
- R4: For a sample at row r < ROWS-1 and column c, the output is registered on the clock edge that accepts the input sample at (r+1, c). For a sample at row ROWS-1 and column c, the output is registered on the (c+1)-th clock edge after the edge that accepts the final sample (ROWS-1, COLS-1).
- R5: A suppressed sample produces no output cycle. Accepting a row-0 sample never produces an output on the next cycle.
- R6: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_hi | input | 12 | High (cluster-selecting) threshold |
| thr_lo | input | 12 | Low (cluster-gathering) threshold |
| in_valid | input | 1 | Input sample present this cycle |
| in_row | input | RW | Row index of the input sample |
| in_col | input | CW | Column index of the input sample |
| in_data | input | 12 | Input sample value, unsigned |
| out_valid | output | 1 | Kept sample present on the output |
| out_row | output | RW | Row of the kept sample |
| out_col | output | CW | Column of the kept sample |
| out_data | output | 12 | Value of the kept sample |

## Verification
Two things happen on the same clock edge, the edge that accepts the frame's final sample. On that edge the block gives its verdict on the last column of row ROWS-2, and it also starts the drain sweep. One cycle later the drain gives its first verdict, on column 0 of the last row. The bench drives every frame back to back, so these two events always land on adjacent edges. It also places directed clusters in the corners, where the west and north zero fill apply together (and the east and south zero fill on the opposite corner). Every cycle the bench compares `out_valid` and the output fields with a bench-side cross model that indexes its own frame array with bounds checks. The comparison is made at the exact cycle the latency rule predicts.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int SAMPLE_W = 12;
  typedef logic [SAMPLE_W-1:0] sample_t;

  // number of cross values strictly above thr
  function automatic logic [2:0] count_above(sample_t c, sample_t n, sample_t s,
                                             sample_t e, sample_t w, sample_t thr);
    logic [2:0] k;
    k = 3'd0;
    if (c > thr) k = k + 3'd1;
    if (n > thr) k = k + 3'd1;
    if (s > thr) k = k + 3'd1;
    if (e > thr) k = k + 3'd1;
    if (w > thr) k = k + 3'd1;
    return k;
  endfunction

  function automatic logic cross_keep(sample_t c, sample_t n, sample_t s,
                                      sample_t e, sample_t w,
                                      sample_t hi, sample_t lo);
    return (count_above(c, n, s, e, w, hi) >= 3'd1) &&
           (count_above(c, n, s, e, w, lo) >= 3'd2);
  endfunction
endpackage

// File: rtl/zs_linebuf.sv
module zs_linebuf
  import zs_pkg::*;
#(
  parameter int COLS = 8,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          step_en,
  input  logic [CW-1:0] step_col,
  input  sample_t       south,
  output sample_t       center,
  output sample_t       north_raw,
  output sample_t       west_raw,
  output sample_t       east_z
);
  sample_t cur_row  [COLS];
  sample_t prev_row [COLS];
  sample_t w_hold;

  logic          at_last;
  logic [CW-1:0] e_idx;

  assign at_last   = (step_col == CW'(COLS - 1));
  assign e_idx     = at_last ? step_col : step_col + CW'(1);
  assign center    = cur_row[step_col];
  assign north_raw = prev_row[step_col];
  assign west_raw  = w_hold;
  assign east_z    = at_last ? '0 : cur_row[e_idx];

  always_ff @(posedge clk) begin
    if (step_en) begin
      prev_row[step_col] <= cur_row[step_col];
      cur_row[step_col]  <= south;
      w_hold             <= cur_row[step_col];
    end
  end
endmodule

// File: rtl/zs_decide.sv
module zs_decide
  import zs_pkg::*;
#(
  parameter int RW = 3,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [RW-1:0] c_row,
  input  logic [CW-1:0] c_col,
  input  sample_t       center,
  input  sample_t       north,
  input  sample_t       south,
  input  sample_t       east,
  input  sample_t       west,
  input  sample_t       thr_hi,
  input  sample_t       thr_lo,
  output logic          out_valid,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output sample_t       out_data
);
  logic keep_fire;
  assign keep_fire = go && cross_keep(center, north, south, east, west, thr_hi, thr_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= keep_fire;
      if (keep_fire) begin
        out_row  <= c_row;
        out_col  <= c_col;
        out_data <= center;
      end
    end
  end

  // R3: emitted value is the centre presented on the deciding step
  p_center_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    keep_fire |=> (out_data == $past(center) && out_col == $past(c_col)));

  // R5: a step with no go never yields an output
  p_no_go_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !out_valid);
endmodule

// File: rtl/zs_cross2d.sv
module zs_cross2d
  import zs_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS + 1),
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sample_t       thr_hi,
  input  sample_t       thr_lo,
  input  logic          in_valid,
  input  logic [RW-1:0] in_row,
  input  logic [CW-1:0] in_col,
  input  sample_t       in_data,
  output logic          out_valid,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output sample_t       out_data
);
  logic          draining;
  logic [CW-1:0] dcol;
  logic          last_in;

  logic          step_en;
  logic [RW-1:0] step_row;
  logic [CW-1:0] step_col;
  sample_t       south;
  logic          go;

  sample_t center, north_raw, west_raw, east_z, north_z, west_z;

  assign last_in  = in_valid && !draining &&
                    (in_row == RW'(ROWS - 1)) && (in_col == CW'(COLS - 1));
  assign step_en  = draining || in_valid;
  assign step_row = draining ? RW'(ROWS) : in_row;
  assign step_col = draining ? dcol : in_col;
  assign south    = draining ? '0 : in_data;
  assign go       = step_en && (step_row != '0);
  assign north_z  = (step_row == RW'(1)) ? '0 : north_raw;
  assign west_z   = (step_col == '0) ? '0 : west_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      dcol     <= '0;
    end else if (draining) begin
      if (dcol == CW'(COLS - 1)) begin
        draining <= 1'b0;
        dcol     <= '0;
      end else begin
        dcol <= dcol + CW'(1);
      end
    end else if (last_in) begin
      draining <= 1'b1;
      dcol     <= '0;
    end
  end

  zs_linebuf #(.COLS(COLS)) u_lb (
    .clk      (clk),
    .step_en  (step_en),
    .step_col (step_col),
    .south    (south),
    .center   (center),
    .north_raw(north_raw),
    .west_raw (west_raw),
    .east_z   (east_z)
  );

  zs_decide #(.RW(RW), .CW(CW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .c_row    (step_row - RW'(1)),
    .c_col    (step_col),
    .center   (center),
    .north    (north_z),
    .south    (south),
    .east     (east_z),
    .west     (west_z),
    .thr_hi   (thr_hi),
    .thr_lo   (thr_lo),
    .out_valid(out_valid),
    .out_row  (out_row),
    .out_col  (out_col),
    .out_data (out_data)
  );

  // R5: accepting a row-0 sample produces no output next cycle
  p_row0_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !draining && in_row == '0) |=> !out_valid);

  // R3: emitted coordinates lie inside the array
  p_coords_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row < RW'(ROWS) && out_col <= CW'(COLS - 1)));

  // R4: the drain sweep lasts exactly COLS steps
  p_drain_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> $past(dcol) == CW'(COLS - 1));

  // R4: the final sample always arms the drain
  p_drain_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> (draining && dcol == '0));

  // R6: output idle while reset is held
  p_reset_idle_r6: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/zs_cross2d_bench.sv
module zs_cross2d_bench;
  import zs_pkg::*;
  localparam int ROWS = 6;
  localparam int COLS = 8;
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS);
  localparam int NPIX = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  sample_t thr_hi = '0, thr_lo = '0;
  logic in_valid = 1'b0;
  logic [RW-1:0] in_row = '0;
  logic [CW-1:0] in_col = '0;
  sample_t in_data = '0;
  logic out_valid;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;
  sample_t out_data;

  int checks = 0, errors = 0;
  sample_t img [NPIX];

  always #5 clk = ~clk;

  zs_cross2d #(.ROWS(ROWS), .COLS(COLS)) u_zs_cross2d (
    .clk(clk), .rst_n(rst_n), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .in_valid(in_valid), .in_row(in_row), .in_col(in_col), .in_data(in_data),
    .out_valid(out_valid), .out_row(out_row), .out_col(out_col), .out_data(out_data));

  function automatic int px(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;   // R2 zero fill
    return int'(img[r*COLS + c]);
  endfunction

  function automatic bit model_keep(int r, int c);
    int v [5];
    int nh, nl;
    v[0] = px(r, c); v[1] = px(r-1, c); v[2] = px(r+1, c);
    v[3] = px(r, c-1); v[4] = px(r, c+1);
    nh = 0; nl = 0;
    foreach (v[i]) begin
      if (v[i] > int'(thr_hi)) nh++;
      if (v[i] > int'(thr_lo)) nl++;
    end
    return (nh >= 1) && (nl >= 2);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one frame back to back and compare every output cycle
  task automatic run_frame(string tag);
    for (int t = 0; t < NPIX + COLS; t++) begin
      if (t < NPIX) begin
        in_valid = 1'b1;
        in_row = RW'(t / COLS);
        in_col = CW'(t % COLS);
        in_data = img[t];
      end else begin
        in_valid = 1'b0;
        in_data = '0;
      end
      @(negedge clk);
      if (t < COLS) begin
        chk(out_valid == 1'b0, {"R5 row0 ", tag}, int'(out_valid), 0);
      end else begin
        int idx, r, c;
        bit e;
        idx = t - COLS; r = idx / COLS; c = idx % COLS;
        e = model_keep(r, c);
        chk(out_valid == e, {"R1/R4 keep ", tag}, int'(out_valid), int'(e));
        if (e && out_valid) begin
          chk(int'(out_row) == r && int'(out_col) == c, {"R3 coords ", tag},
              int'(out_row)*100 + int'(out_col), r*100 + c);
          chk(int'(out_data) == px(r, c), {"R3 data ", tag}, int'(out_data), px(r, c));
        end
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, {"R5 idle after drain ", tag}, int'(out_valid), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset", int'(out_valid), 0);
    rst_n = 1'b1;

    // all zero frame: nothing kept (R1)
    thr_hi = 12'd100; thr_lo = 12'd10;
    foreach (img[i]) img[i] = '0;
    run_frame("zeros");

    // corner clusters exercise zero fill (R2)
    foreach (img[i]) img[i] = '0;
    img[0] = 12'd200; img[1] = 12'd50;
    img[NPIX-1] = 12'd300; img[NPIX-2] = 12'd40; img[NPIX-1-COLS] = 12'd20;
    run_frame("R2 corners");

    // strict comparison: value equal to thr_hi does not select (R1)
    foreach (img[i]) img[i] = 12'd11;
    img[3*COLS + 4] = 12'd100;
    run_frame("R1 equal hi");
    img[3*COLS + 4] = 12'd101;
    run_frame("R1 above hi");
    // value equal to thr_lo does not gather
    foreach (img[i]) img[i] = 12'd10;
    img[2*COLS + 2] = 12'd500;
    run_frame("R1 equal lo");

    // random frames with random thresholds
    for (int f = 0; f < 6; f++) begin
      thr_hi = sample_t'(600 + ($urandom % 1500));
      thr_lo = sample_t'(8 + ($urandom % 60));
      foreach (img[i])
        img[i] = (($urandom % 5) == 0) ? sample_t'($urandom % 4096)
                                       : sample_t'($urandom % 64);
      run_frame("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule